// File: doc/BRIEF.md
# Two-Way Cache Flush Walker

This block empties a two-way set-associative cache in hardware. Software sets a flush control bit with a one-cycle pulse. The sequencer then takes ownership of the tag/state port and reads every entry. It visits the indices of way 0 from lowest to highest, then restarts at index 0 and visits way 1 in the same order. For every valid entry it raises one castout request for each modified sector, lowest sector first. It waits for each request to be acknowledged before it looks at anything else. The castout data movement belongs to the bus side and is not part of this block.

After the read walk, a second sweep in the same way-major order writes every tag entry invalid. The block then clears the control bit itself. A cleared bit means the tags hold no valid entries. It does not mean that queued copybacks have drained. While the flush runs, the L1 instruction and data request paths are blocked. A snoop request always has priority on the tag port. While a snoop is present the walker holds its place and continues at the same index and way.

States: IDLE (waiting for the bit), READ (examine the current entry), SCAN (select the next modified sector), WAIT_ACK (castout outstanding), INVAL (invalidation sweep) and DONE (clear the bit). The transitions are:
- IDLE→READ when the bit is set.
- READ→SCAN on a valid entry with modified sectors.
- READ→READ on a snoop, or on advance to the next entry.
- READ→INVAL after the last entry of way 1.
- SCAN→WAIT_ACK while sectors remain.
- SCAN→READ or SCAN→INVAL when no sectors remain.
- WAIT_ACK→SCAN on acknowledge.
- INVAL→INVAL per entry or on a snoop.
- INVAL→DONE after the last entry.
- DONE→IDLE, which also clears the bit.

Top module: `hwf_flush_seq`

## Requirements
- R1: After reset the flush bit, busy, l1_block, tag_en, tag_we and co_req are all low.
- R2: A flush_set pulse sets flush_bit on the next clock edge, and busy rises one edge later. A flush_set pulse while busy is high has no effect: the flush is not restarted and runs to its normal end.
- R3: Entries are visited way-major. Way 0 is walked from index 0 to the highest index, then way 1 from index 0 to the highest index.
- R4: For each valid entry, one castout is issued per set bit of its dirty mask, in ascending sector order. Invalid entries and clean sectors produce no castout. A castout carries co_way, co_idx and co_sector.
- R5: co_req stays high with stable co_way, co_idx and co_sector until co_ack is sampled high. Only after that does the walker examine another sector or entry.
- R6: After the read walk, every entry receives one tag_we write, which clears its valid bit and its dirty mask. At the end no entry is valid.
- R7: l1_block is high in every cycle in which busy is high, and low otherwise.
- R8: While snoop_req is high, tag_en and tag_we are low. The walk then continues at the same entry, so the castout order is unchanged.
- R9: Once invalidation is done, flush_bit and busy fall on the same edge, and busy never stays high after flush_bit is low. If no snoops occur and no castouts are issued, busy stays high for exactly 4·2^IDX_W+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush_set | input | 1 | One-cycle software write that sets the flush bit |
| flush_bit | output | 1 | Flush control bit; cleared by hardware when the flush completes |
| busy | output | 1 | Flush in progress |
| l1_block | output | 1 | Blocks L1 instruction and data requests to the cache |
| snoop_req | input | 1 | Snoop needs the tag port this cycle (priority) |
| tag_en | output | 1 | Walker uses the tag port this cycle |
| tag_we | output | 1 | Invalidate entry at tag_way/tag_idx (clear valid and dirty) |
| tag_idx | output | IDX_W | Index being accessed |
| tag_way | output | 1 | Way being accessed |
| tag_rd_valid | input | 1 | Valid bit of the addressed entry (combinational read) |
| tag_rd_dirty | input | SECTORS | Per-sector modified mask of the addressed entry |
| co_req | output | 1 | Castout request |
| co_ack | input | 1 | Castout accepted |
| co_idx | output | IDX_W | Castout index |
| co_way | output | 1 | Castout way |
| co_sector | output | SEC_W | Castout sector number |

## Verification
The assertions check three things on every cycle. Snoop priority on the tag port holds, a pending castout keeps its request and address, and busy is covered by the flush bit. They also check the wrap of the way-major counter from the last index of way 0 into way 1 and back to the start. Some properties can only be seen across a whole flush, so the bench's scenarios show them. These are the full order of castouts against a tag model, the sectors skipped because they are clean or invalid, the empty tag array at the end, and the busy duration of a clean flush. They also show that a second trigger during a flush is absorbed, and that snoop stalls leave the order intact.

// File: rtl/hwf_pkg.sv
package hwf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_SCAN,
        ST_WAIT_ACK,
        ST_INVAL,
        ST_DONE
    } hwf_state_e;
endpackage

// File: rtl/hwf_sector_pick.sv
module hwf_sector_pick #(
    parameter int N = 4,
    localparam int SW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  mask,
    output logic          any,
    output logic [SW-1:0] pick
);
    // lower_set[i] is high when some bit below i is set
    logic [N:0] lower_set;
    assign lower_set[0] = 1'b0;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_chain
            assign lower_set[g+1] = lower_set[g] | mask[g];
        end
    endgenerate

    always_comb begin
        pick = '0;
        for (int i = 0; i < N; i++) begin
            if (mask[i] && !lower_set[i]) pick = SW'(i);
        end
    end

    assign any = lower_set[N];

    // R4: the chosen sector is always one of the modified ones
    always_comb begin
        if (any === 1'b1)
            assert_pick_in_mask_R4: assert (mask[pick]);
    end
endmodule

// File: rtl/hwf_walk_ctr.sv
module hwf_walk_ctr #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    output logic [IDX_W-1:0] idx,
    output logic             way,
    output logic             last
);
    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
            way <= 1'b0;
        end else if (clr) begin
            idx <= '0;
            way <= 1'b0;
        end else if (step) begin
            if (idx == IDX_MAX) begin
                idx <= '0;
                way <= ~way;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    assign last = (idx == IDX_MAX) && way;

    // R3: way 0 finishes then way 1 starts at index 0
    assert_way_switch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && idx == IDX_MAX && !way) |=> (way && idx == '0));
    // R3: the walk wraps to the start after the last entry
    assert_walk_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && last) |=> (!way && idx == '0));
    // R3: indices ascend by one inside a way
    assert_idx_ascend_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && idx != IDX_MAX) |=> (idx == $past(idx) + 1'b1 && $stable(way)));
endmodule

// File: rtl/hwf_flush_seq.sv
module hwf_flush_seq
    import hwf_pkg::*;
#(
    parameter int IDX_W   = 4,
    parameter int SECTORS = 4,
    localparam int SEC_W  = (SECTORS > 1) ? $clog2(SECTORS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush_set,
    output logic               flush_bit,
    output logic               busy,
    output logic               l1_block,
    input  logic               snoop_req,
    output logic               tag_en,
    output logic               tag_we,
    output logic [IDX_W-1:0]   tag_idx,
    output logic               tag_way,
    input  logic               tag_rd_valid,
    input  logic [SECTORS-1:0] tag_rd_dirty,
    output logic               co_req,
    input  logic               co_ack,
    output logic [IDX_W-1:0]   co_idx,
    output logic               co_way,
    output logic [SEC_W-1:0]   co_sector
);
    hwf_state_e         state_q, state_d;
    logic [SECTORS-1:0] mask_q;
    logic [SEC_W-1:0]   sector_q;
    logic               bit_q;
    logic               start, step, walk_last;
    logic               mask_any;
    logic [SEC_W-1:0]   pick_sec;
    logic               entry_hit;

    hwf_walk_ctr #(.IDX_W(IDX_W)) u_walk (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .step  (step),
        .idx   (tag_idx),
        .way   (tag_way),
        .last  (walk_last)
    );

    hwf_sector_pick #(.N(SECTORS)) u_pick (
        .mask (mask_q),
        .any  (mask_any),
        .pick (pick_sec)
    );

    assign entry_hit = tag_rd_valid && (|tag_rd_dirty);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and walker control
    always_comb begin
        state_d = state_q;
        start   = 1'b0;
        step    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (bit_q) begin
                    start   = 1'b1;
                    state_d = ST_READ;
                end
            end
            ST_READ: begin
                if (!snoop_req) begin
                    if (entry_hit) begin
                        state_d = ST_SCAN;
                    end else begin
                        step    = 1'b1;
                        state_d = walk_last ? ST_INVAL : ST_READ;
                    end
                end
            end
            ST_SCAN: begin
                if (mask_any) begin
                    state_d = ST_WAIT_ACK;
                end else begin
                    step    = 1'b1;
                    state_d = walk_last ? ST_INVAL : ST_READ;
                end
            end
            ST_WAIT_ACK: begin
                if (co_ack) state_d = ST_SCAN;
            end
            ST_INVAL: begin
                if (!snoop_req) begin
                    step    = 1'b1;
                    state_d = walk_last ? ST_DONE : ST_INVAL;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath registers: control bit, sector mask, selected sector
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q    <= 1'b0;
            mask_q   <= '0;
            sector_q <= '0;
        end else begin
            if (state_q == ST_DONE)  bit_q <= 1'b0;
            else if (flush_set)      bit_q <= 1'b1;

            if (state_q == ST_READ && !snoop_req && entry_hit)
                mask_q <= tag_rd_dirty;
            else if (state_q == ST_WAIT_ACK && co_ack)
                mask_q[sector_q] <= 1'b0;

            if (state_q == ST_SCAN && mask_any)
                sector_q <= pick_sec;
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        l1_block  = busy;
        flush_bit = bit_q;
        tag_en    = 1'b0;
        tag_we    = 1'b0;
        co_req    = 1'b0;
        unique case (state_q)
            ST_READ:     tag_en = !snoop_req;
            ST_INVAL: begin
                tag_en = !snoop_req;
                tag_we = !snoop_req;
            end
            ST_WAIT_ACK: co_req = 1'b1;
            ST_IDLE, ST_SCAN, ST_DONE: ;
            default: ;
        endcase
        co_idx    = tag_idx;
        co_way    = tag_way;
        co_sector = sector_q;
    end

    // R8: a snoop owns the tag port
    assert_snoop_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_req |-> (!tag_en && !tag_we));
    // R5: a pending castout holds its request and address
    assert_castout_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (co_req && !co_ack) |=> (co_req && $stable(co_sector) && $stable(co_idx) && $stable(co_way)));
    // R9: busy is always covered by the control bit
    assert_busy_needs_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> flush_bit);
    // R9: the bit clears together with the end of busy
    assert_clear_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flush_bit) |-> !busy);
    // R6: no invalidating write while a castout is pending
    assert_no_write_in_castout_R6: assert property (@(posedge clk) disable iff (!rst_n)
        co_req |-> !tag_we);
    // R2: the walk starts only after the bit was set
    assert_start_after_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(flush_bit));
endmodule

// File: tb/test_hwf_flush_seq.sv
`timescale 1ns/100ps
module test_hwf_flush_seq;
    localparam int IDX_W   = 4;
    localparam int SECTORS = 4;
    localparam int SEC_W   = 2;
    localparam int E       = 1 << IDX_W;
    localparam int KW      = 1 + IDX_W + SEC_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush_set = 1'b0, snoop_req = 1'b0, co_ack = 1'b0;
    logic flush_bit, busy, l1_block, tag_en, tag_we, tag_way, co_req, co_way;
    logic [IDX_W-1:0] tag_idx, co_idx;
    logic [SEC_W-1:0] co_sector;
    logic tag_rd_valid;
    logic [SECTORS-1:0] tag_rd_dirty;

    logic tv [2][E];
    logic [SECTORS-1:0] td [2][E];
    logic [KW-1:0] exp_q [$];

    int n_tests = 0, n_fail = 0;
    int ack_dly = 0;
    int snoop_on = 0;
    int busy_cycles = 0;
    int cyc = 0;
    logic done_flag = 1'b0;

    always #2.5 clk = ~clk;

    hwf_flush_seq #(.IDX_W(IDX_W), .SECTORS(SECTORS)) i_hwf_flush_seq (
        .clk(clk), .rst_n(rst_n), .flush_set(flush_set), .flush_bit(flush_bit),
        .busy(busy), .l1_block(l1_block), .snoop_req(snoop_req),
        .tag_en(tag_en), .tag_we(tag_we), .tag_idx(tag_idx), .tag_way(tag_way),
        .tag_rd_valid(tag_rd_valid), .tag_rd_dirty(tag_rd_dirty),
        .co_req(co_req), .co_ack(co_ack), .co_idx(co_idx), .co_way(co_way),
        .co_sector(co_sector)
    );

    // tag array model
    always_comb begin
        tag_rd_valid = tv[tag_way][tag_idx];
        tag_rd_dirty = td[tag_way][tag_idx];
    end
    always @(posedge clk) begin
        if (tag_we) begin
            tv[tag_way][tag_idx] <= 1'b0;
            td[tag_way][tag_idx] <= '0;
        end
    end

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // driver: load the tag model and queue the expected castouts
    task automatic load(input int kind);
        exp_q.delete();
        for (int w = 0; w < 2; w++) begin
            for (int i = 0; i < E; i++) begin
                case (kind)
                    0: begin tv[w][i] = 1'b1; td[w][i] = '0; end
                    1: begin tv[w][i] = (i % 3 != 0); td[w][i] = SECTORS'(i * 5 + w * 3); end
                    default: begin tv[w][i] = 1'b1; td[w][i] = '1; end
                endcase
                if (tv[w][i])
                    for (int s = 0; s < SECTORS; s++)
                        if (td[w][i][s]) exp_q.push_back({w[0], IDX_W'(i), SEC_W'(s)});
            end
        end
    endtask

    // castout responder, drives just after the edge
    initial begin
        int wait_n;
        wait_n = 0;
        forever begin
            @(posedge clk); #1;
            cyc++;
            snoop_req = (snoop_on != 0) && (cyc % 7 == 3 || cyc % 11 == 0);
            if (co_ack) co_ack = 1'b0;
            else if (co_req) begin
                if (wait_n >= ack_dly) begin co_ack = 1'b1; wait_n = 0; end
                else wait_n++;
            end
        end
    end

    // monitor: compares castouts and per-cycle rules
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) busy_cycles++;
            // R7
            if (l1_block !== busy) check(1'b0, "R7", "l1_block vs busy", l1_block, busy);
            // R8
            if (snoop_req && (tag_en || tag_we)) check(1'b0, "R8", "tag port used during snoop", tag_en, 0);
            if (co_req && co_ack) begin
                if (exp_q.size() == 0) check(1'b0, "R4", "unexpected castout", {co_way, co_idx, co_sector}, -1);
                else begin
                    logic [KW-1:0] e;
                    e = exp_q.pop_front();
                    check({co_way, co_idx, co_sector} == e, "R3/R4", "castout way/idx/sector",
                          {co_way, co_idx, co_sector}, e);
                end
            end
        end
    end

    task automatic pulse_set();
        @(posedge clk); #1; flush_set = 1'b1;
        @(posedge clk); #1; flush_set = 1'b0;
    endtask

    task automatic wait_done();
        int t;
        t = 0;
        do begin @(negedge clk); t++; end while ((flush_bit || busy) && t < 20000);
    endtask

    task automatic check_end(input string tag);
        int nv;
        nv = 0;
        for (int w = 0; w < 2; w++)
            for (int i = 0; i < E; i++) nv += tv[w][i];
        check(nv == 0, "R6", {tag, " valid entries left"}, nv, 0);
        check(exp_q.size() == 0, "R4", {tag, " castouts missing"}, exp_q.size(), 0);
        check(!flush_bit && !busy, "R9", {tag, " bit/busy after end"}, {flush_bit, busy}, 0);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int w = 0; w < 2; w++) for (int i = 0; i < E; i++) begin tv[w][i] = 0; td[w][i] = '0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!flush_bit && !busy && !l1_block, "R1", "bit/busy/block after reset", {flush_bit, busy, l1_block}, 0);
        check(!tag_en && !tag_we && !co_req, "R1", "port requests after reset", {tag_en, tag_we, co_req}, 0);

        // scenario A: clean cache, timing
        load(0);
        busy_cycles = 0;
        pulse_set();                      // flush_set sampled at the edge before this point
        @(negedge clk);
        // after the sampling edge plus one: bit high, walk starting next edge
        check(flush_bit == 1'b1, "R2", "flush_bit one edge after set", flush_bit, 1);
        @(negedge clk);
        check(busy == 1'b1, "R2", "busy one edge after bit", busy, 1);
        wait_done();
        check(busy_cycles == 4 * E + 1, "R9", "clean flush busy cycles", busy_cycles, 4 * E + 1);
        check_end("A");

        // scenario B: mixed valid/dirty, short ack delay
        load(1);
        ack_dly = 1;
        pulse_set();
        wait_done();
        check_end("B");

        // scenario C: snoops during flush, slow acks, re-trigger mid-flush
        load(1);
        ack_dly = 3;
        snoop_on = 1;
        pulse_set();
        repeat (20) @(negedge clk);
        check(busy == 1'b1, "R2", "still busy before re-trigger", busy, 1);
        pulse_set();                      // R2: ignored while busy
        wait_done();
        snoop_on = 0;
        repeat (4) @(negedge clk);
        check(!busy && !flush_bit, "R2", "no restart after set while busy", {busy, flush_bit}, 0);
        check_end("C");

        // scenario D: every sector dirty, immediate acks
        load(2);
        ack_dly = 0;
        pulse_set();
        wait_done();
        check_end("D");

        done_flag = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule